// File: doc/BRIEF.md
# Single-precision floating-point add/subtract datapath

This block takes two single-precision operands (1 sign bit, 8 biased exponent bits with bias 127, 23 fraction bits, hidden leading one) and either adds them or subtracts the second from the first. It produces an unrounded, normalised result: a sign, a biased exponent, a 24-bit significand that includes the hidden bit, and guard, round and sticky bits. A separate rounding stage consumes these outputs.

Inside, the block first compares the two magnitudes and measures the exponent gap. It then shifts the smaller operand right by that gap. Next it adds or subtracts the two significands, and finally it normalises the result in either direction. The result is registered in one stage. Operands are assumed normal: denormals, infinities and NaNs are not handled. The result exponent is assumed to stay inside the normal range.

Top module: `fpadd_core`

## Requirements
- R1: `valid_o` is high in exactly the cycles that follow a clock edge at which `valid_i` was high. The result fields belong to that operand pair.
- R2: When `sub_i` is 1 the block computes a − b, by treating the sign bit (bit 31) of `b_i` as inverted. When `sub_i` is 0 it computes a + b.
- R3: An effective addition (equal effective signs) yields the truncated exact sum. When the sum carries out, the significand moves right one place and the exponent rises by one. `exp_o` is never below the larger input exponent.
- R4: When the effective signs differ, the smaller magnitude is subtracted from the larger one. The result takes the sign of the larger magnitude.
- R5: A difference with leading zeros is shifted left, and the exponent is lowered by the shift count. Every nonzero result has `sig_o[23]` = 1.
- R6: A zero result drives the sign, the exponent, the significand and the guard, round and sticky bits all to zero.
- R7: `guard_o` is the first bit of the exact result below the significand LSB, and `round_o` is the next bit. `sticky_o` is the OR of all exact-result bits below the round position.
- R8: When the exponent gap is 27 or more, the smaller operand contributes only a sticky one. For an effective addition this gives `sig_o` equal to the larger significand, guard = round = 0 and sticky = 1.
- R9: While `rst_ni` is low, `valid_o` and every result field read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand pair present |
| a_i | input | 32 | First operand, single precision |
| b_i | input | 32 | Second operand, single precision |
| sub_i | input | 1 | 1: compute a − b |
| valid_o | output | 1 | Result present |
| sign_o | output | 1 | Result sign |
| exp_o | output | 8 | Result biased exponent |
| sig_o | output | 24 | Normalised significand with hidden bit |
| guard_o | output | 1 | First bit below the significand |
| round_o | output | 1 | Second bit below the significand |
| sticky_o | output | 1 | OR of all lower bits |

## Verification
Every result appears one clock edge after its operands are taken, so `valid_o` and all fields are due at the next falling edge after the rising edge that captured `valid_i`. The driver applies operands on falling edges and places the expected fields in a queue. The monitor samples just after each falling edge, pops one item per `valid_o` cycle, and also checks that `valid_o` mirrors the `valid_i` seen at the preceding rising edge. The expected fields come from an exact wide-integer sum that is truncated in the bench.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int XTR_W  = 3;               // guard, round, one extra exact bit
  localparam int ALN_W  = SIG_W + XTR_W;   // exact part of aligned operand
  localparam int EXT_W  = ALN_W + 1;       // plus sticky
  localparam int LZ_W   = $clog2(EXT_W + 1);
endpackage

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int W    = 28,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     v_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (v_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              eff_sub_o,
  output logic [EXT_W-1:0]  big_o,
  output logic [EXT_W-1:0]  small_o
);
  logic                sgn_a, sgn_b, a_big;
  logic [WORD_W-2:0]   mag_l, mag_s;
  logic [EXP_W-1:0]    e_s, gap;
  logic [SIG_W-1:0]    m_l, m_s;
  logic [2*ALN_W-1:0]  wide;
  logic [ALN_W-1:0]    kept;
  logic                lost;

  assign sgn_a     = a_i[WORD_W-1];
  assign sgn_b     = b_i[WORD_W-1] ^ sub_i;
  assign a_big     = a_i[WORD_W-2:0] >= b_i[WORD_W-2:0];
  assign mag_l     = a_big ? a_i[WORD_W-2:0] : b_i[WORD_W-2:0];
  assign mag_s     = a_big ? b_i[WORD_W-2:0] : a_i[WORD_W-2:0];
  assign exp_o     = mag_l[WORD_W-2:FRAC_W];
  assign e_s       = mag_s[WORD_W-2:FRAC_W];
  assign m_l       = {1'b1, mag_l[FRAC_W-1:0]};
  assign m_s       = {1'b1, mag_s[FRAC_W-1:0]};
  assign gap       = exp_o - e_s;
  assign sign_o    = a_big ? sgn_a : sgn_b;
  assign eff_sub_o = sgn_a ^ sgn_b;

  always_comb begin
    wide = {m_s, {XTR_W{1'b0}}, {ALN_W{1'b0}}} >> gap;
    kept = wide[2*ALN_W-1:ALN_W];
    lost = |wide[ALN_W-1:0];
    if (gap >= EXP_W'(ALN_W)) begin
      kept = '0;
      lost = 1'b1;
    end
  end

  assign big_o   = {m_l, {(XTR_W+1){1'b0}}};
  assign small_o = {kept, lost};
endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub
  import fpadd_pkg::*;
(
  input  logic             eff_sub_i,
  input  logic [EXT_W-1:0] big_i,
  input  logic [EXT_W-1:0] small_i,
  output logic [EXT_W:0]   res_o
);
  // sticky taken as one LSB gives the exact borrow above it
  assign res_o = eff_sub_i ? ({1'b0, big_i} - {1'b0, small_i})
                           : ({1'b0, big_i} + {1'b0, small_i});
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
(
  input  logic [EXT_W:0]   res_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             zero_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             guard_o,
  output logic             round_o,
  output logic             sticky_o
);
  logic [LZ_W-1:0]    lz;
  logic [EXT_W-1:0]   sh;
  logic [EXP_W+1:0]   e;

  fpadd_lzc #(.W(EXT_W), .CNT_W(LZ_W)) u_lzc (
    .v_i   (res_i[EXT_W-1:0]),
    .cnt_o (lz)
  );

  assign zero_o = (res_i == '0);

  always_comb begin
    if (res_i[EXT_W]) begin
      sh = {res_i[EXT_W:2], res_i[1] | res_i[0]};
      e  = {2'b00, exp_i} + 1'b1;
    end else begin
      sh    = res_i[EXT_W-1:0] << lz;
      sh[0] = sh[0] | res_i[0];
      e     = {2'b00, exp_i} - {{(EXP_W+2-LZ_W){1'b0}}, lz};
    end
  end

  assign exp_o    = zero_o ? '0 : e[EXP_W-1:0];
  assign sig_o    = zero_o ? '0 : sh[EXT_W-1:XTR_W+1];
  assign guard_o  = ~zero_o & sh[XTR_W];
  assign round_o  = ~zero_o & sh[XTR_W-1];
  assign sticky_o = ~zero_o & (|sh[XTR_W-2:0]);
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic              valid_o,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]  sig_o,
  output logic              guard_o,
  output logic              round_o,
  output logic              sticky_o
);
  logic             al_sign, al_sub;
  logic [EXP_W-1:0] al_exp;
  logic [EXT_W-1:0] al_big, al_small;
  logic [EXT_W:0]   as_res;
  logic             n_zero, n_g, n_r, n_s;
  logic [EXP_W-1:0] n_exp;
  logic [SIG_W-1:0] n_sig;

  fpadd_align u_align (
    .a_i       (a_i),
    .b_i       (b_i),
    .sub_i     (sub_i),
    .sign_o    (al_sign),
    .exp_o     (al_exp),
    .eff_sub_o (al_sub),
    .big_o     (al_big),
    .small_o   (al_small)
  );

  fpadd_addsub u_addsub (
    .eff_sub_i (al_sub),
    .big_i     (al_big),
    .small_i   (al_small),
    .res_o     (as_res)
  );

  fpadd_norm u_norm (
    .res_i    (as_res),
    .exp_i    (al_exp),
    .zero_o   (n_zero),
    .exp_o    (n_exp),
    .sig_o    (n_sig),
    .guard_o  (n_g),
    .round_o  (n_r),
    .sticky_o (n_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sign_o   <= 1'b0;
      exp_o    <= '0;
      sig_o    <= '0;
      guard_o  <= 1'b0;
      round_o  <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sign_o   <= al_sign & ~n_zero;
        exp_o    <= n_exp;
        sig_o    <= n_sig;
        guard_o  <= n_g;
        round_o  <= n_r;
        sticky_o <= n_s;
      end
    end
  end
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk
  import fpadd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              sub_i,
  input logic              valid_o,
  input logic              sign_o,
  input logic [EXP_W-1:0]  exp_o,
  input logic [SIG_W-1:0]  sig_o,
  input logic              guard_o,
  input logic              round_o,
  input logic              sticky_o
);
  logic [EXP_W-1:0] ea, eb, emax;
  logic             eff_add, a_wide_gap, a_larger;

  assign ea         = a_i[WORD_W-2:FRAC_W];
  assign eb         = b_i[WORD_W-2:FRAC_W];
  assign emax       = (ea >= eb) ? ea : eb;
  assign eff_add    = a_i[WORD_W-1] == (b_i[WORD_W-1] ^ sub_i);
  assign a_wide_gap = {1'b0, ea} >= ({1'b0, eb} + (EXP_W+1)'(ALN_W));
  assign a_larger   = a_i[WORD_W-2:0] > b_i[WORD_W-2:0];

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R1
  AST_ADD_EXP_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eff_add) |=> exp_o >= $past(emax));  // R3
  AST_LARGER_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_larger) |=> sign_o == $past(a_i[WORD_W-1]));  // R4
  AST_NORMALISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sig_o != '0) |-> sig_o[SIG_W-1]);  // R5
  AST_ZERO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sig_o == '0) |-> (exp_o == '0 && !sign_o && !guard_o && !round_o && !sticky_o));  // R6
  AST_GAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eff_add && a_wide_gap) |=>
      (sticky_o && !guard_o && !round_o && sig_o == {1'b1, $past(a_i[FRAC_W-1:0])}));  // R8
endmodule

bind fpadd_core fpadd_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .sub_i    (sub_i),
  .valid_o  (valid_o),
  .sign_o   (sign_o),
  .exp_o    (exp_o),
  .sig_o    (sig_o),
  .guard_o  (guard_o),
  .round_o  (round_o),
  .sticky_o (sticky_o)
);

// File: tb/tb_fpadd_core.sv
module tb_fpadd_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        sub_i = 1'b0;
  logic        valid_o, sign_o, guard_o, round_o, sticky_o;
  logic [7:0]  exp_o;
  logic [23:0] sig_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [35:0] exp_q[$];
  string       tag_q[$];
  logic        last_vin = 1'b0;

  always #2 clk = ~clk;

  fpadd_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .valid_o(valid_o), .sign_o(sign_o), .exp_o(exp_o), .sig_o(sig_o),
    .guard_o(guard_o), .round_o(round_o), .sticky_o(sticky_o)
  );

  // exact wide sum, truncated: {sign, exp, sig, g, r, s}
  function automatic logic [35:0] model(logic [31:0] a, logic [31:0] b, logic sub);
    logic sa, sb, sl;
    logic [7:0] el, es;
    logic [23:0] ml, ms;
    int d, p, e;
    logic [127:0] v, w;
    sa = a[31]; sb = b[31] ^ sub;
    if (a[30:0] >= b[30:0]) begin
      sl = sa; el = a[30:23]; es = b[30:23]; ml = {1'b1, a[22:0]}; ms = {1'b1, b[22:0]};
    end else begin
      sl = sb; el = b[30:23]; es = a[30:23]; ml = {1'b1, b[22:0]}; ms = {1'b1, a[22:0]};
    end
    d = int'(el) - int'(es);
    if (d > 40) d = 40;
    v = 128'(ml) << d;
    if (sa == sb) v = v + 128'(ms);
    else          v = v - 128'(ms);
    if (v == '0) return '0;
    p = 0;
    for (int i = 0; i < 128; i++) if (v[i]) p = i;
    w = v << (127 - p);
    e = int'(el) - d + p - 23;
    return {sl, e[7:0], w[127:104], w[103], w[102], |w[101:0]};
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic sub, input string tag);
    @(negedge clk);
    a_i = a; b_i = b; sub_i = sub; valid_i = 1'b1;
    exp_q.push_back(model(a, b, sub));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_ni && !done) begin
      if (last_vin || valid_o) begin
        n_cmp++;
        if (valid_o !== last_vin) begin
          n_bad++;
          $display("FAIL R1 valid_o got %b expected %b", valid_o, last_vin);
        end
      end
      if (valid_o) begin
        logic [35:0] got, want;
        string t;
        got = {sign_o, exp_o, sig_o, guard_o, round_o, sticky_o};
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R1 unexpected result got %h expected none", got);
        end else begin
          want = exp_q.pop_front();
          t = tag_q.pop_front();
          n_cmp++;
          if (got !== want) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h got %h expected %h", t, 0, 0, got, want);
          end
        end
      end
      last_vin = valid_i;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({valid_o, sign_o, exp_o, sig_o, guard_o, round_o, sticky_o} !== '0) begin
      n_bad++;
      $display("FAIL R9 reset outputs got %h expected 0",
               {valid_o, sign_o, exp_o, sig_o, guard_o, round_o, sticky_o});
    end
    rst_ni = 1'b1;
    idle(2);
    send(32'h3F800000, 32'h3F800000, 1'b0, "R3 carry 1+1");
    send(32'h3FC00000, 32'h3FA00000, 1'b0, "R3 carry 1.5+1.25");
    send(32'h3F800000, 32'h3F800000, 1'b1, "R6 R2 1-1 zero");
    idle(1);
    send(32'h40400000, 32'hBF800000, 1'b0, "R4 3+(-1)");
    send(32'hBF800000, 32'h40400000, 1'b0, "R4 -1+3");
    send(32'h3F800000, 32'h40400000, 1'b1, "R2 R4 1-3");
    send(32'h3F800001, 32'h3F800000, 1'b1, "R5 cancel to 2^-23");
    send(32'h30800000, 32'h3F800000, 1'b0, "R8 wide gap add");
    send(32'h3F800000, 32'h30800000, 1'b1, "R7 wide gap sub");
    send(32'h3F800000, 32'h33C00000, 1'b0, "R7 guard round set");
    send(32'h3F800000, 32'h33A00000, 1'b0, "R7 guard sticky");
    send(32'hC2C80000, 32'h42C80000, 1'b1, "R3 negative add");
    send(32'h3FFFFFFF, 32'h3FFFFFFE, 1'b1, "R5 long cancel");
    idle(2);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = {1'($urandom), 8'(100 + $urandom % 50), 23'($urandom)};
      if (i % 3 == 0) b = {1'($urandom), a[30:23], 23'($urandom)};
      else            b = {1'($urandom), 8'(100 + $urandom % 50), 23'($urandom)};
      send(a, b, 1'($urandom), "R7 random");
      if (i % 17 == 0) idle(1);
    end
    idle(3);
    n_cmp++;
    if (exp_q.size() != 0 || valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 pending results got %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule